// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the read path of a memory controller. When the ECC checker signals a correctable (single-bit) or uncorrectable (multi-bit) fault, the block records it in one 32-bit register. The register keeps the upper address bits and the syndrome of the fault, plus a sticky flag that says which kind of fault it was. After a fault is recorded, the register holds it until software clears the flag, so the first fault is never overwritten by later ones.

Software reaches the register through a plain write strobe with write data and a combinational read-data bus. Three bits of the register are software controls. One stops the write-back of corrected data. One lets a correctable fault raise a non-maskable interrupt request. One lets an uncorrectable fault raise a system-error request. A scrub-request output tells the write-back path when a corrected read should be written back to memory.

Top module: `ecc_err_capture`

## Requirements
- R1: After a synchronous active-high reset, the register reads 0x00000000 and `nmi_req`, `serr_req` and `scrub_req` are low.
- R2: A `ce_pulse` while both flags are clear is latched on that clock edge. Bit 0 becomes 1, bits 30:12 take `err_addr[31:13]` and bits 11:4 take `err_syn`.
- R3: A `ue_pulse` while both flags are clear is latched on that clock edge. Bit 1 becomes 1 and the address and syndrome fields are filled as in R2.
- R4: If `ce_pulse` and `ue_pulse` arrive in the same cycle while both flags are clear, only bit 1 is set. The address and syndrome of that cycle are latched.
- R5: While bit 0 or bit 1 is set, fault pulses have no effect. Bits 30:0 stay unchanged unless software writes.
- R6: A write with a 1 in bit 0 or bit 1 clears that flag. A 0 in those bit positions leaves the flag as it was. A new capture happens only after both flags are clear.
- R7: Bits 31, 3 and 2 are read/write controls that take the write data. Bits 30:4 cannot be changed by a write.
- R8: `nmi_req` is high exactly while bit 0 and bit 2 are both 1.
- R9: `serr_req` is high exactly while bit 1 and bit 3 are both 1.
- R10: `scrub_req` is high in the same cycle as `ce_pulse` when bit 31 is 0. It is low whenever bit 31 is 1 or `ce_pulse` is low.
- R11: Bits 1 and 0 are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_pulse | input | 1 | Correctable (single-bit) fault this cycle |
| ue_pulse | input | 1 | Uncorrectable (multi-bit) fault this cycle |
| err_addr | input | 32 | Address of the faulting read |
| err_syn | input | 8 | Syndrome of the faulting read |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register contents |
| nmi_req | output | 1 | Non-maskable interrupt request, level |
| serr_req | output | 1 | System-error request, level |
| scrub_req | output | 1 | Write back the corrected read data |

## Verification
The hardest case to reach from the ports is two events on one clock edge. Examples are a clearing write that lands on the same edge as a fault pulse, or a fault that arrives when one flag is set and the other is being cleared. Random stimulus gives a real chance of these coincidences. Fault pulses occur often, and write data is random across all 32 bits, so clears, control changes and writes to read-only bits overlap with faults. Directed steps add the simultaneous-pulse case, the write-zero case and the frozen-register case.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    parameter int ADDR_W   = 32;
    parameter int SYN_W    = 8;
    parameter int REG_W    = 32;
    parameter int ADDR_KEEP = 19;

    localparam int ADDR_LO   = ADDR_W - ADDR_KEEP;
    localparam int FLAG_CE   = 0;
    localparam int FLAG_UE   = 1;
    localparam int BIT_NMI   = 2;
    localparam int BIT_SERR  = 3;
    localparam int SYN_LSB   = 4;
    localparam int ADDR_LSB  = SYN_LSB + SYN_W;
    localparam int BIT_NOSCR = ADDR_LSB + ADDR_KEEP;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CE   = 2'd1,
        EV_UE   = 2'd2
    } ecc_event_t;

    typedef struct packed {
        logic [ADDR_KEEP-1:0] addr_hi;
        logic [SYN_W-1:0]     syn;
        logic                 ue;
        logic                 ce;
    } ecc_capture_t;

    typedef struct packed {
        logic no_scrub;
        logic serr_en;
        logic nmi_en;
    } ecc_ctrl_t;

    // Uncorrectable outranks correctable when both arrive together.
    function automatic ecc_event_t classify(input logic ce, input logic ue);
        if (ue)
            return EV_UE;
        else if (ce)
            return EV_CE;
        return EV_NONE;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input ecc_capture_t c,
                                                  input ecc_ctrl_t k);
        logic [REG_W-1:0] r;
        r = '0;
        r[BIT_NOSCR]                       = k.no_scrub;
        r[ADDR_LSB +: ADDR_KEEP]           = c.addr_hi;
        r[SYN_LSB +: SYN_W]                = c.syn;
        r[BIT_SERR]                        = k.serr_en;
        r[BIT_NMI]                         = k.nmi_en;
        r[FLAG_UE]                         = c.ue;
        r[FLAG_CE]                         = c.ce;
        return r;
    endfunction

endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ecc_ctrl_t        ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.no_scrub <= wdata[BIT_NOSCR];
            ctrl.serr_en  <= wdata[BIT_SERR];
            ctrl.nmi_en   <= wdata[BIT_NMI];
        end
    end
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_pulse,
    input  logic              ue_pulse,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              wr,
    input  logic [1:0]        clr_bits,
    output ecc_capture_t      cap
);
    ecc_event_t   ev;
    logic         armed;
    ecc_capture_t cap_nxt;
    logic         unused_addr_lo;

    assign unused_addr_lo = ^err_addr[ADDR_LO-1:0];
    assign ev    = classify(ce_pulse, ue_pulse);
    assign armed = !(cap.ce || cap.ue);

    always_comb begin
        cap_nxt = cap;
        if (armed && ev != EV_NONE) begin
            cap_nxt.addr_hi = err_addr[ADDR_W-1:ADDR_LO];
            cap_nxt.syn     = err_syn;
            cap_nxt.ue      = (ev == EV_UE);
            cap_nxt.ce      = (ev == EV_CE);
        end else if (wr) begin
            cap_nxt.ue = cap.ue && !clr_bits[FLAG_UE];
            cap_nxt.ce = cap.ce && !clr_bits[FLAG_CE];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cap <= '0;
        else
            cap <= cap_nxt;
    end
endmodule

// File: rtl/ecc_cap_signal.sv
module ecc_cap_signal
    import ecc_cap_pkg::*;
(
    input  ecc_capture_t cap,
    input  ecc_ctrl_t    ctrl,
    input  logic         ce_pulse,
    output logic         nmi_req,
    output logic         serr_req,
    output logic         scrub_req
);
    assign nmi_req   = cap.ce && ctrl.nmi_en;
    assign serr_req  = cap.ue && ctrl.serr_en;
    assign scrub_req = ce_pulse && !ctrl.no_scrub;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_pulse,
    input  logic              ue_pulse,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [SYN_W-1:0]  err_syn,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              nmi_req,
    output logic              serr_req,
    output logic              scrub_req
);
    ecc_ctrl_t    ctrl;
    ecc_capture_t cap;

    ecc_cap_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    ecc_cap_store u_store (
        .clk      (clk),
        .rst      (rst),
        .ce_pulse (ce_pulse),
        .ue_pulse (ue_pulse),
        .err_addr (err_addr),
        .err_syn  (err_syn),
        .wr       (reg_wr),
        .clr_bits (reg_wdata[1:0]),
        .cap      (cap)
    );

    ecc_cap_signal u_sig (
        .cap       (cap),
        .ctrl      (ctrl),
        .ce_pulse  (ce_pulse),
        .nmi_req   (nmi_req),
        .serr_req  (serr_req),
        .scrub_req (scrub_req)
    );

    assign reg_rdata = pack_reg(cap, ctrl);
endmodule

// File: rtl/ecc_cap_chk.sv
module ecc_cap_chk (
    input logic        clk,
    input logic        rst,
    input logic        ce_pulse,
    input logic        ue_pulse,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        nmi_req,
    input logic        serr_req,
    input logic        scrub_req
);
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones(reg_rdata[1:0]) <= 1); // R11

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((|reg_rdata[1:0]) && !reg_wr) |=> $stable(reg_rdata[30:0])); // R5

    AST_UE_WINS: assert property (@(posedge clk) disable iff (rst)
        (ue_pulse && reg_rdata[1:0] == 2'b00) |=> (reg_rdata[1:0] == 2'b10)); // R4

    AST_CE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ce_pulse && !ue_pulse && reg_rdata[1:0] == 2'b00) |=> (reg_rdata[1:0] == 2'b01)); // R2

    AST_NMI_SRC: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> (reg_rdata[0] && reg_rdata[2])); // R8

    AST_SERR_SRC: assert property (@(posedge clk) disable iff (rst)
        serr_req |-> (reg_rdata[1] && reg_rdata[3])); // R9

    AST_SCRUB_GATE: assert property (@(posedge clk) disable iff (rst)
        scrub_req |-> (ce_pulse && !reg_rdata[31])); // R10
endmodule

bind ecc_err_capture ecc_cap_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_pulse  (ce_pulse),
    .ue_pulse  (ue_pulse),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .nmi_req   (nmi_req),
    .serr_req  (serr_req),
    .scrub_req (scrub_req)
);

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;
    logic        clk = 0;
    logic        rst = 1;
    logic        ce_pulse = 0, ue_pulse = 0, reg_wr = 0;
    logic [31:0] err_addr = 0, reg_wdata = 0;
    logic [7:0]  err_syn = 0;
    logic [31:0] reg_rdata;
    logic        nmi_req, serr_req, scrub_req;

    int total = 0;
    int bad = 0;
    logic [31:0] model = 0;

    always #10 clk = ~clk;

    ecc_err_capture u0 (
        .clk(clk), .rst(rst), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
        .err_addr(err_addr), .err_syn(err_syn), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req),
        .serr_req(serr_req), .scrub_req(scrub_req)
    );

    function automatic logic [31:0] next_model(input logic [31:0] cur,
        input logic ce, input logic ue, input logic [31:0] a,
        input logic [7:0] s, input logic wr, input logic [31:0] wd);
        logic [31:0] n;
        n = cur;
        if (cur[1:0] == 2'b00 && (ce || ue)) begin
            n[30:12] = a[31:13];
            n[11:4]  = s;
            n[1:0]   = ue ? 2'b10 : 2'b01;
        end else if (wr) begin
            n[1:0] = cur[1:0] & ~wd[1:0];
        end
        if (wr) begin
            n[31] = wd[31];
            n[3]  = wd[3];
            n[2]  = wd[2];
        end
        return n;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic ce, input logic ue, input logic [31:0] a,
                        input logic [7:0] s, input logic wr,
                        input logic [31:0] wd, input string req);
        @(negedge clk);
        ce_pulse = ce; ue_pulse = ue; err_addr = a; err_syn = s;
        reg_wr = wr; reg_wdata = wd;
        #1;
        check("R10", "scrub_req", {31'b0, scrub_req}, {31'b0, ce && !model[31]});
        model = next_model(model, ce, ue, a, s, wr, wd);
        @(posedge clk);
        #1;
        ce_pulse = 0; ue_pulse = 0; reg_wr = 0;
        check(req, "reg_rdata", reg_rdata, model);
        check("R8", "nmi_req", {31'b0, nmi_req}, {31'b0, model[0] && model[2]});
        check("R9", "serr_req", {31'b0, serr_req}, {31'b0, model[1] && model[3]});
        check("R11", "flags", {31'b0, model[1] && model[0]}, 32'b0);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R1", "reg_rdata", reg_rdata, 32'h0);
        check("R1", "outputs", {29'b0, nmi_req, serr_req, scrub_req}, 32'h0);

        // enable both requests, scrub allowed
        step(0, 0, 0, 0, 1, 32'h0000_000C, "R7");
        // correctable fault
        step(1, 0, 32'hDEAD_BEEF, 8'h5A, 0, 0, "R2");
        // later faults ignored
        step(0, 1, 32'h1234_5678, 8'hC3, 0, 0, "R5");
        step(1, 0, 32'hFFFF_FFFF, 8'hFF, 0, 0, "R5");
        // write zeros to flags and ones to read-only bits: no effect on them
        step(0, 0, 0, 0, 1, 32'h7FFF_FFFC, "R6");
        // clear the flag
        step(0, 0, 0, 0, 1, 32'h0000_000D, "R6");
        // uncorrectable fault
        step(0, 1, 32'h8000_2000, 8'h81, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 32'h0000_000E, "R6");
        // both at once
        step(1, 1, 32'h0F0F_F0F0, 8'h3C, 0, 0, "R4");
        // clear, disable scrub, then a correctable fault
        step(0, 0, 0, 0, 1, 32'h8000_0002, "R7");
        step(1, 0, 32'hA5A5_A5A5, 8'h11, 0, 0, "R10");
        step(0, 0, 0, 0, 1, 32'h0000_0001, "R6");

        for (int i = 0; i < 2000; i++) begin
            logic ce, ue, wr;
            ce = ($urandom % 4) == 0;
            ue = ($urandom % 6) == 0;
            wr = ($urandom % 3) == 0;
            step(ce, ue, $urandom, 8'($urandom), wr, $urandom, "R5_mixed");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule